// File: doc/BRIEF.md
# Relocatable Peripheral Base Decoder

This block holds one 32-bit configuration word. The word places a 1 KB window of on-chip peripheral registers anywhere in a 32-bit address space. For every access, the block decides whether the access is served by that internal window or is sent to the external bus. The decision is purely combinational. It uses the access address and a 3-bit access-space code (CPU space, or supervisor/user combined with code/data).

The word has three parts. A valid flag enables internal decoding. A base field selects the 1 KB window. A set of per-space mask bits forces accesses of a chosen space out to the external bus, even when they fall inside the window.

Reset clears only the valid flag. Until software writes a word with the flag set, every access goes external. The stored word can always be read back.

Top module: `periph_base_decoder`

## Requirements
- R1: While rst_ni is low, and after reset until the first write, the valid flag (readback bit 0) is 0. All other stored bits are undefined until written.
- R2: While the valid flag is 0, int_sel_o is 0 and ext_sel_o is 1 for every address and space code.
- R3: The word layout is as follows. Bits [31:10] hold the base. Bit k+1 masks space code k, for k = 0 CPU space, 1 supervisor code, 2 supervisor data, 3 user code, 4 user data. Bit 0 is the valid flag. Bits [9:6] are stored but have no decode effect.
- R4: With the valid flag at 1, an access is internal when acc_addr_i[31:10] equals the base field, its space code is 0..4, and that space's mask bit is 0.
- R5: An access whose space mask bit is 1 goes external even when its address lies in the window.
- R6: Space codes 5, 6 and 7 are never internal.
- R7: int_sel_o and ext_sel_o follow the access inputs combinationally in the same cycle, and exactly one of them is 1 at all times.
- R8: A write (wr_en_i high at a rising clock edge) replaces the whole word at that edge. rd_data_o then returns the full stored word.
- R9: The window is exactly 1 KB. The address just below the base and the address just above base+0x3FF go external.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Word to store |
| rd_data_o | output | 32 | Stored word readback |
| acc_addr_i | input | 32 | Access address |
| acc_space_i | input | 3 | Access-space code (0..4 defined, 5..7 reserved) |
| int_sel_o | output | 1 | Access is served by the internal window |
| ext_sel_o | output | 1 | Access goes to the external bus |

## Verification
The bench drives accesses at the first and last word of the window and one word beyond each edge. A comparator off by one bit would let a neighbouring 1 KB page decode as internal.

It sets each mask bit on its own and walks all eight space codes. A wrong bit-to-space mapping would mask the wrong space, and a decoder that ignored reserved codes would select internal for codes 5..7.

It also clears the valid flag after the design has been running with a window in place. A design that kept decoding on a stale base would keep answering internal.

Randomised accesses, clustered around the base, are checked every cycle against a behavioural model. The same model checks the one-hot relation between the two outputs.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned MASK_LSB  = 1;

  typedef enum logic [2:0] {
    SP_CPU      = 3'd0,
    SP_SUP_CODE = 3'd1,
    SP_SUP_DATA = 3'd2,
    SP_USR_CODE = 3'd3,
    SP_USR_DATA = 3'd4
  } space_e;
endpackage

// File: rtl/pbd_cfg_reg.sv
module pbd_cfg_reg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic              valid_q;
  logic [WORD_W-1:1] rest_q;

  // only the valid flag is reset; the rest stays undefined until written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (wr_en_i) valid_q <= wr_data_i[pbd_pkg::VALID_BIT];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) rest_q <= wr_data_i[WORD_W-1:1];
  end

  assign word_o = {rest_q, valid_q};

  // R8
  wr_takes_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (word_o == $past(wr_data_i)));
endmodule

// File: rtl/pbd_space_mask.sv
module pbd_space_mask #(
  parameter int unsigned NUM_SPACES = 5,
  parameter int unsigned SPACE_W    = 3
) (
  input  logic [SPACE_W-1:0]    space_i,
  input  logic [NUM_SPACES-1:0] mask_i,
  output logic                  legal_o,
  output logic                  masked_o
);
  logic [NUM_SPACES-1:0] hit;

  for (genvar k = 0; k < NUM_SPACES; k++) begin : g_hit
    assign hit[k] = (space_i == SPACE_W'(k));
  end

  assign legal_o  = |hit;
  assign masked_o = |(hit & mask_i);

  always_comb begin
    // R6
    hit_onehot_chk: assert ($onehot0(hit) || $isunknown(space_i));
  end
endmodule

// File: rtl/pbd_addr_match.sv
module pbd_addr_match #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BASE_LSB = 10,
  localparam int unsigned BASE_W  = ADDR_W - BASE_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              match_o
);
  assign match_o = (addr_i[ADDR_W-1:BASE_LSB] == base_i);
endmodule

// File: rtl/periph_base_decoder.sv
module periph_base_decoder #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BASE_LSB   = 10,
  parameter int unsigned NUM_SPACES = 5,
  parameter int unsigned SPACE_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_data_i,
  output logic [ADDR_W-1:0]  rd_data_o,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [SPACE_W-1:0] acc_space_i,
  output logic               int_sel_o,
  output logic               ext_sel_o
);
  localparam int unsigned BASE_W   = ADDR_W - BASE_LSB;
  localparam int unsigned MASK_LSB = pbd_pkg::MASK_LSB;
  localparam int unsigned MASK_MSB = MASK_LSB + NUM_SPACES - 1;

  if (MASK_MSB >= BASE_LSB) begin : g_bad_layout
    initial $fatal(1, "mask field overlaps base field");
  end

  logic [ADDR_W-1:0]     word;
  logic                  valid;
  logic [BASE_W-1:0]     base;
  logic [NUM_SPACES-1:0] mask;
  logic                  match, legal, masked;

  pbd_cfg_reg #(.WORD_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .word_o(word)
  );

  assign valid = word[pbd_pkg::VALID_BIT];
  assign base  = word[ADDR_W-1:BASE_LSB];
  assign mask  = word[MASK_MSB:MASK_LSB];

  pbd_addr_match #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_match (
    .addr_i(acc_addr_i), .base_i(base), .match_o(match)
  );

  pbd_space_mask #(.NUM_SPACES(NUM_SPACES), .SPACE_W(SPACE_W)) u_space (
    .space_i(acc_space_i), .mask_i(mask), .legal_o(legal), .masked_o(masked)
  );

  assign int_sel_o = valid & match & legal & ~masked;
  assign ext_sel_o = ~int_sel_o;
  assign rd_data_o = word;

  // R2
  no_int_when_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> !int_sel_o);
  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({int_sel_o, ext_sel_o}) == 1);
  // R4
  int_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> (acc_addr_i[ADDR_W-1:BASE_LSB] == rd_data_o[ADDR_W-1:BASE_LSB]));
  // R5
  int_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> !masked);
  // R6
  int_legal_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> (acc_space_i < SPACE_W'(NUM_SPACES)));
endmodule

// File: tb/periph_base_decoder_bench.sv
`timescale 1ns/1ps
module periph_base_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [31:0] acc_addr_i = '0;
  logic [2:0]  acc_space_i = '0;
  logic        int_sel_o, ext_sel_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_word;
  bit          m_written = 0;

  always #10 clk_i = ~clk_i;

  periph_base_decoder u_periph_base_decoder (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .acc_addr_i, .acc_space_i, .int_sel_o, .ext_sel_o
  );

  function automatic bit model_int(input logic [31:0] w, input logic [31:0] a, input int sp);
    if (!w[0]) return 0;
    if (a[31:10] != w[31:10]) return 0;
    if (sp > 4) return 0;
    if (w[sp+1]) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational outputs, then clock
  task automatic step(input bit we, input logic [31:0] d, input logic [31:0] a,
                      input int sp, input string req);
    bit e;
    @(negedge clk_i);
    wr_en_i = we; wr_data_i = d; acc_addr_i = a; acc_space_i = sp[2:0];
    #1;
    e = m_written ? model_int(m_word, a, sp) : 1'b0;
    chk({req, "/R7 int"}, {31'd0, int_sel_o}, {31'd0, e});
    chk({req, "/R7 ext"}, {31'd0, ext_sel_o}, {31'd0, !e});
    if (m_written) chk({req, "/R8 rd"}, rd_data_o, m_word);
    else           chk({req, "/R1 valid"}, {31'd0, rd_data_o[0]}, 32'd0);
    @(posedge clk_i);
    if (we) begin m_word = d; m_written = 1; end
    #1 wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] base;
    #5;
    // R1 reset state
    chk("R1 reset valid", {31'd0, rd_data_o[0]}, 32'd0);
    chk("R2 reset int", {31'd0, int_sel_o}, 32'd0);
    #30 rst_ni = 1'b1;

    // R2: before any write everything is external
    step(0, 0, 32'h0000_0000, 2, "R2");
    step(0, 0, 32'h4000_0400, 0, "R2");

    // write base with valid clear: still external
    step(1, 32'h4000_0400, 32'h4000_0400, 2, "R2");
    step(0, 0, 32'h4000_0400, 2, "R2");

    // enable window at 0x4000_0400, bits 9:6 also set (R3: no decode effect)
    step(1, 32'h4000_07C1, 32'h4000_0400, 2, "R3");
    for (int sp = 0; sp < 8; sp++) step(0, 0, 32'h4000_0400, sp, "R4/R6");
    // R9 boundaries
    step(0, 0, 32'h4000_07FC, 2, "R9");
    step(0, 0, 32'h4000_0800, 2, "R9");
    step(0, 0, 32'h4000_03FC, 2, "R9");
    step(0, 0, 32'hC000_0400, 2, "R9");

    // R5: each mask bit alone, walk all spaces
    for (int k = 0; k < 5; k++) begin
      step(1, 32'h4000_0401 | (32'd1 << (k + 1)), 32'h4000_0500, 0, "R5");
      for (int sp = 0; sp < 8; sp++) step(0, 0, 32'h4000_0500, sp, "R5/R6");
    end

    // relocate
    step(1, 32'hFFFF_FC01, 32'hFFFF_FFFC, 4, "R8");
    step(0, 0, 32'hFFFF_FFFC, 4, "R4");
    step(0, 0, 32'h4000_0400, 4, "R4");

    // R2: clear valid after running
    step(1, 32'hFFFF_FC00, 32'hFFFF_FC00, 1, "R2");
    step(0, 0, 32'hFFFF_FC00, 1, "R2");

    // randomized traffic clustered near base
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, d;
      bit we;
      we = ($urandom_range(0, 15) == 0);
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
      if ($urandom_range(0, 1) != 0) d[5:1] = '0;
      base = {m_word[31:10], 10'd0};
      case ($urandom_range(0, 3))
        0: a = $urandom;
        1: a = base + 32'($urandom_range(0, 1023));
        2: a = base - 32'($urandom_range(1, 8));
        default: a = base + 32'd1024 + 32'($urandom_range(0, 8));
      endcase
      step(we, d, a, $urandom_range(0, 7), "rand R4/R5");
    end

    finish_run();
  end
endmodule